// File: doc/BRIEF.md
# Host Slice-Protocol Memory Bridge

This block lets a slow external host reach a 16-bit wide memory with 19-bit addresses through only an 8-bit input bus and a 4-bit output bus. The host changes the input bus one step at a time. It marks each new slice by flipping a strobe line. Two command lines choose what the slices mean: load a new current address, write a word, read a word, or update a small set of flag bits. The bridge keeps the current address and builds write words from 4-bit slices. It returns a read word one nibble at a time, and it moves the current address up by one after every memory access, so a block of consecutive locations needs only one address load.

Every input line passes through a two-flop synchroniser and then a settle filter. A bus value is acted on only after it has stayed unchanged for `SETTLE` cycles. The decoder reacts to changes of this filtered value, which it compares with the last value it consumed.

Memory traffic leaves on two valid/ready request channels, one for writes and one for reads. A request stays up with address and data unchanged until ready is seen. The current address steps in the cycle the request is accepted. While a request waits, the decoder consumes no new bus value, and it decodes that value once the request has been accepted. A read result comes back as a one-cycle `rsp_valid` pulse, at least one cycle after the read was accepted, and it cannot be refused.

Top module: `hmb_bridge`

## Requirements
- R1: Input bit 7 is the slice strobe, bit 6 the read command, bit 5 the write command, and bits 4:0 the slice data. An operation begins on a 0-to-1 change of the strobe. The command pair {read, write} then picks the operation: 11 loads the address, 01 writes, 10 reads, 00 updates the flags.
- R2: Address load takes four slices with alternating strobe levels 1, 0, 1, 0. The first three slices, sent with both commands at 1, carry address bits 4:0, 9:5 and 14:10 on data bits 4:0. The fourth slice, sent with both commands at 0, carries bits 18:15 on data bits 3:0. The fourth slice makes the result the current address.
- R3: A write takes four slices with strobe levels 1, 0, 1, 0. Each slice carries one nibble on data bits 3:0, least significant nibble first. The first three slices have the write command at 1 and the fourth has both commands at 0. After the fourth slice, `wr_valid` rises with `wr_addr` equal to the current address and `wr_data` equal to the assembled word.
- R4: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold. The current address steps by one in the cycle the write is accepted.
- R5: The first read slice raises `rd_valid` at the current address. It holds, with a stable address, until `rd_ready`. The current address steps by one on acceptance, and the word on `rsp_valid` is latched whole.
- R6: After the read response, `host_out` shows nibble 0 (bits 3:0). The following slices, at strobe levels 0, 1, 0 with the read command at 1, 1, 0, select nibbles 1, 2 and 3. `host_out` then holds its value until the next read response.
- R7: The current address wraps from 0x7FFFF to 0x00000.
- R8: The flag update is four bus values in order: strobe 1 with commands 0; then all lines 0; then only the write command at 1, with no strobe change; then strobe and commands at 0 with the flag values on data bits 4:0. `flags` takes those bits. Flag bit 0 is the host-control flag.
- R9: A bus value that does not fit the expected next step ends the operation and returns to idle. This covers an all-zero bus in the middle of an operation. It issues no memory request and leaves the current address unchanged.
- R10: After reset, no request is raised, `host_out` and `flags` are 0, and the current address is 0.
- R11: While a write or read request waits, the decoder consumes no bus change. It decodes that change after acceptance, and write and read requests are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_in | input | 8 | Host bus: strobe, read command, write command, slice data |
| host_out | output | 4 | Nibble of the read word returned to the host |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 19 | Write address |
| wr_data | output | 16 | Write word |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | 19 | Read address |
| rsp_valid | input | 1 | Read result valid (one-cycle pulse) |
| rsp_data | input | 16 | Read result |
| flags | output | FLAG_W | Flag bits set by the host; bit 0 is host control |

## Verification
The bench loads addresses whose high slice is all zero. A decoder that waited for a nonzero bus there would never load them. Loading 0x7FFFF is followed by a read, which must go to 0, so a counter that saturates or misses the increment is caught. Operations are cut off with an all-zero bus partway through. An implementation that commits partial address slices, or that issues a write anyway, shows a wrong address or an extra request on the next write. Holding `wr_ready` and `rd_ready` low checks that requests stay stable. It also checks that a read slice sent during the stall is decoded afterwards rather than lost or acted on early.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  localparam int BUS_W    = 8;
  localparam int STRB_BIT = 7;
  localparam int RCMD_BIT = 6;
  localparam int WCMD_BIT = 5;
  localparam int SLICE_W  = 5;
  localparam int NIB_W    = 4;
  localparam int ASM_W    = 3 * SLICE_W;
  localparam int ADDR_W   = ASM_W + NIB_W;
  localparam int NIB_CNT  = 4;
  localparam int DATA_W   = NIB_CNT * NIB_W;

  typedef enum logic [1:0] {
    CMD_SET = 2'b00,
    CMD_WR  = 2'b01,
    CMD_RD  = 2'b10,
    CMD_ADR = 2'b11
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADR1,
    ST_ADR2,
    ST_ADR3,
    ST_WR1,
    ST_WR2,
    ST_WR3,
    ST_WR_REQ,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_RD_SRV,
    ST_SET1,
    ST_SET2,
    ST_SET3
  } st_e;
endpackage

// File: rtl/hmb_settle.sv
module hmb_settle #(
  parameter int W      = 8,
  parameter int SETTLE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  generate
    if (SETTLE == 0) begin : g_bypass
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout <= '0;
        else        dout <= s2_q;
      end
    end else begin : g_filter
      localparam int CW = $clog2(SETTLE + 1);
      logic [W-1:0]  cand_q;
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cand_q <= '0;
          cnt_q  <= '0;
          dout   <= '0;
        end else if (s2_q != cand_q) begin
          cand_q <= s2_q;
          cnt_q  <= '0;
        end else if (cnt_q != CW'(SETTLE)) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          dout <= cand_q;
        end
      end

      // R1: the filtered bus only takes a value the candidate stage already held
      p_settled_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> (dout == $past(cand_q)));
    end
  endgenerate
endmodule

// File: rtl/hmb_addr.sv
module hmb_addr import hmb_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= '0;
    else if (load) cur <= load_val;
    else if (inc)  cur <= cur + 1'b1;
  end

  // R7: one step per accepted access, wrapping at the top of the space
  p_step_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (cur == ADDR_W'($past(cur) + 1'b1)));
  // R2: a completed address load becomes the current address
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur == $past(load_val)));
  // R9: without load or access, the current address stays put
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !inc) |=> $stable(cur));
endmodule

// File: rtl/hmb_decoder.sv
module hmb_decoder import hmb_pkg::*; #(
  parameter int FLAG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              addr_load,
  output logic [ADDR_W-1:0] addr_val,
  output logic              addr_inc,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [NIB_W-1:0]  host_out,
  output logic [FLAG_W-1:0] flags
);
  st_e               st_q;
  logic [BUS_W-1:0]  seen_q;
  logic [ASM_W-1:0]  asm_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_word_q;
  logic [DATA_W-1:0] nib_sh;
  logic [1:0]        nib_idx;
  logic [NIB_W-1:0]  out_q;
  logic [FLAG_W-1:0] flags_q;

  logic busy, ev, tgl, rise, fall, srv_ok;
  cmd_e cmd;

  assign busy = (st_q == ST_WR_REQ) || (st_q == ST_RD_REQ) || (st_q == ST_RD_WAIT);
  assign ev   = !busy && (bus != seen_q);
  assign tgl  = bus[STRB_BIT] ^ seen_q[STRB_BIT];
  assign rise = tgl && bus[STRB_BIT];
  assign fall = tgl && !bus[STRB_BIT];
  assign cmd  = cmd_e'({bus[RCMD_BIT], bus[WCMD_BIT]});

  always_comb begin
    case (nib_idx)
      2'd1:    srv_ok = fall && (cmd == CMD_RD);
      2'd2:    srv_ok = rise && (cmd == CMD_RD);
      2'd3:    srv_ok = fall && (cmd == CMD_SET);
      default: srv_ok = 1'b0;
    endcase
  end

  assign nib_sh    = rd_word_q >> {nib_idx, 2'b00};
  assign addr_load = (st_q == ST_ADR3) && ev && fall && (cmd == CMD_SET);
  assign addr_val  = {bus[NIB_W-1:0], asm_q};
  assign wr_valid  = (st_q == ST_WR_REQ);
  assign rd_valid  = (st_q == ST_RD_REQ);
  assign addr_inc  = (wr_valid && wr_ready) || (rd_valid && rd_ready);
  assign wr_data   = wd_q;
  assign host_out  = out_q;
  assign flags     = flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      seen_q    <= '0;
      asm_q     <= '0;
      wd_q      <= '0;
      rd_word_q <= '0;
      nib_idx   <= '0;
      out_q     <= '0;
      flags_q   <= '0;
    end else begin
      if (ev) seen_q <= bus;
      case (st_q)
        ST_IDLE: if (ev && rise) begin
          case (cmd)
            CMD_ADR: begin asm_q[4:0]  <= bus[SLICE_W-1:0]; st_q <= ST_ADR1; end
            CMD_WR:  begin wd_q[3:0]   <= bus[NIB_W-1:0];   st_q <= ST_WR1;  end
            CMD_RD:  st_q <= ST_RD_REQ;
            default: st_q <= ST_SET1;
          endcase
        end
        ST_ADR1: if (ev) begin
          if (fall && cmd == CMD_ADR) begin asm_q[9:5] <= bus[SLICE_W-1:0]; st_q <= ST_ADR2; end
          else st_q <= ST_IDLE;
        end
        ST_ADR2: if (ev) begin
          if (rise && cmd == CMD_ADR) begin asm_q[14:10] <= bus[SLICE_W-1:0]; st_q <= ST_ADR3; end
          else st_q <= ST_IDLE;
        end
        ST_ADR3: if (ev) st_q <= ST_IDLE;
        ST_WR1: if (ev) begin
          if (fall && cmd == CMD_WR) begin wd_q[7:4] <= bus[NIB_W-1:0]; st_q <= ST_WR2; end
          else st_q <= ST_IDLE;
        end
        ST_WR2: if (ev) begin
          if (rise && cmd == CMD_WR) begin wd_q[11:8] <= bus[NIB_W-1:0]; st_q <= ST_WR3; end
          else st_q <= ST_IDLE;
        end
        ST_WR3: if (ev) begin
          if (fall && cmd == CMD_SET) begin wd_q[15:12] <= bus[NIB_W-1:0]; st_q <= ST_WR_REQ; end
          else st_q <= ST_IDLE;
        end
        ST_WR_REQ: if (wr_ready) st_q <= ST_IDLE;
        ST_RD_REQ: if (rd_ready) st_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (rsp_valid) begin
          rd_word_q <= rsp_data;
          out_q     <= rsp_data[NIB_W-1:0];
          nib_idx   <= 2'd1;
          st_q      <= ST_RD_SRV;
        end
        ST_RD_SRV: if (ev) begin
          if (srv_ok) begin
            out_q <= nib_sh[NIB_W-1:0];
            if (nib_idx == 2'd3) st_q <= ST_IDLE;
            else nib_idx <= nib_idx + 1'b1;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_SET1: if (ev) st_q <= (fall && bus == '0) ? ST_SET2 : ST_IDLE;
        ST_SET2: if (ev) st_q <= (!tgl && bus[STRB_BIT:WCMD_BIT] == 3'b001) ? ST_SET3 : ST_IDLE;
        ST_SET3: if (ev) begin
          if (bus[STRB_BIT:WCMD_BIT] == 3'b000) flags_q <= bus[FLAG_W-1:0];
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R4: a stalled write keeps its request, address and word
  p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(cur_addr) && $stable(wd_q)));
  // R5: a stalled read keeps its request and address
  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(cur_addr)));
  // R11: never both requests at once
  p_one_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid));
  // R11: no bus value is consumed while a request waits
  p_stall_consume_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || rd_valid) |=> $stable(seen_q));
  // R8: flags move only at the last step of the update sequence
  p_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != $past(flags_q)) |-> ($past(st_q) == ST_SET3));
  // R6: the returned nibble only moves on a response or a consumed slice
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid && !ev) |=> $stable(out_q));
endmodule

// File: rtl/hmb_bridge.sv
module hmb_bridge import hmb_pkg::*; #(
  parameter int SETTLE = 2,
  parameter int FLAG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        host_in,
  output logic [3:0]        host_out,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [18:0]       wr_addr,
  output logic [15:0]       wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [18:0]       rd_addr,
  input  logic              rsp_valid,
  input  logic [15:0]       rsp_data,
  output logic [FLAG_W-1:0] flags
);
  logic [BUS_W-1:0]  bus_f;
  logic [ADDR_W-1:0] cur_addr, addr_val;
  logic              addr_load, addr_inc;

  hmb_settle #(.W(BUS_W), .SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst_n(rst_n), .din(host_in), .dout(bus_f)
  );

  hmb_decoder #(.FLAG_W(FLAG_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus(bus_f), .cur_addr(cur_addr),
    .addr_load(addr_load), .addr_val(addr_val), .addr_inc(addr_inc),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .host_out(host_out), .flags(flags)
  );

  hmb_addr u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val(addr_val),
    .inc(addr_inc), .cur(cur_addr)
  );

  assign wr_addr = cur_addr;
  assign rd_addr = cur_addr;
endmodule

// File: tb/hmb_bridge_bench.sv
`timescale 1ns/1ps
module hmb_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_in = 8'h00;
  logic [3:0]  host_out;
  logic        wr_valid, rd_valid;
  logic        wr_ready = 1'b1;
  logic        rd_ready = 1'b1;
  logic [18:0] wr_addr, rd_addr;
  logic [15:0] wr_data;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_data = 16'h0;
  logic [4:0]  flags;

  int checks = 0;
  int fails  = 0;
  int wcnt = 0;
  int rcnt = 0;
  logic [18:0] last_waddr = '0, last_raddr = '0, paddr = '0;
  logic [15:0] last_wdata = '0;
  logic        pend = 1'b0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  hmb_bridge u_hmb_bridge (
    .clk(clk), .rst_n(rst_n), .host_in(host_in), .host_out(host_out),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .flags(flags)
  );

  function automatic logic [15:0] mem_f(logic [18:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[18:16], 13'h0};
  endfunction

  // memory model: accepted read answered one cycle later
  always @(posedge clk) begin
    rsp_valid <= pend;
    rsp_data  <= mem_f(paddr);
    pend      <= rd_valid && rd_ready;
    if (rd_valid && rd_ready) begin
      paddr      <= rd_addr;
      last_raddr <= rd_addr;
      rcnt       <= rcnt + 1;
    end
    if (wr_valid && wr_ready) begin
      last_waddr <= wr_addr;
      last_wdata <= wr_data;
      wcnt       <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] v);
    @(negedge clk);
    host_in = v;
    repeat (16) @(negedge clk);
  endtask

  task automatic set_addr(input logic [18:0] a);
    put({3'b111, a[4:0]});
    put({3'b011, a[9:5]});
    put({3'b111, a[14:10]});
    put({4'b0000, a[18:15]});
  endtask

  task automatic do_write(input logic [15:0] d);
    put({4'b1010, d[3:0]});
    put({4'b0010, d[7:4]});
    put({4'b1010, d[11:8]});
    put({4'b0000, d[15:12]});
  endtask

  task automatic do_read(output logic [15:0] w);
    put(8'hC0); w[3:0]   = host_out;
    put(8'h40); w[7:4]   = host_out;
    put(8'hC0); w[11:8]  = host_out;
    put(8'h00); w[15:12] = host_out;
  endtask

  task automatic apply(input logic [4:0] f);
    put(8'h80);
    put(8'h00);
    put(8'h20);
    put({3'b000, f});
  endtask

  localparam int NV = 6;
  localparam logic [34:0] VECS [NV] = '{
    {19'h00000, 16'h0000},
    {19'h7FFFF, 16'hFFFF},
    {19'h2AAAA, 16'h1234},
    {19'h55555, 16'hBEEF},
    {19'h00010, 16'h8001},
    {19'h7FFFE, 16'hC3A5}
  };

  initial begin
    repeat (2000000 / 4 / 20) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    int w0, r0;
    repeat (5) @(negedge clk);
    // R10: reset state
    chk(host_out == 4'h0, "R10 host_out", 32'(host_out), 0);
    chk(flags == 5'h0, "R10 flags", 32'(flags), 0);
    chk(!wr_valid && !rd_valid, "R10 no request", 32'({wr_valid, rd_valid}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_write(16'h1357);
    chk(wcnt == 1 && last_waddr == 19'h0, "R10 address zero", 32'(last_waddr), 0);

    // table walk: R1, R2, R3, R5, R6, R7
    for (int i = 0; i < NV; i++) begin
      logic [18:0] a;
      logic [15:0] d;
      a = VECS[i][34:16];
      d = VECS[i][15:0];
      w0 = wcnt;
      r0 = rcnt;
      set_addr(a);
      do_write(d);
      chk(wcnt == w0 + 1 && last_waddr == a, "R2 write address", 32'(last_waddr), 32'(a));
      chk(last_wdata == d, "R3 write word", 32'(last_wdata), 32'(d));
      do_read(w);
      chk(rcnt == r0 + 1 && last_raddr == 19'(a + 1'b1), "R7 read after write steps",
          32'(last_raddr), 32'(19'(a + 1'b1)));
      chk(w == mem_f(19'(a + 1'b1)), "R6 read nibbles", 32'(w), 32'(mem_f(19'(a + 1'b1))));
    end

    // R8 flag update, R6 hold after read
    w = mem_f(19'h7FFFF);
    apply(5'h13);
    chk(flags == 5'h13, "R8 flags set", 32'(flags), 32'h13);
    chk(host_out == w[15:12], "R6 hold after read", 32'(host_out), 32'(w[15:12]));
    apply(5'h00);
    chk(flags == 5'h00, "R8 flags clear", 32'(flags), 0);

    // R9 aborts
    set_addr(19'h00100);
    w0 = wcnt;
    put(8'hA5);
    put(8'h26);
    put(8'h00);
    repeat (10) @(negedge clk);
    chk(wcnt == w0 && !wr_valid, "R9 aborted write silent", 32'(wcnt), 32'(w0));
    do_write(16'h0F0F);
    chk(last_waddr == 19'h00100, "R9 address kept", 32'(last_waddr), 32'h100);
    put(8'hE5);
    put(8'h6A);
    put(8'h00);
    do_write(16'h7777);
    chk(last_waddr == 19'h00101, "R9 partial address dropped", 32'(last_waddr), 32'h101);

    // R4 / R11 write back-pressure
    set_addr(19'h01234);
    @(negedge clk) wr_ready = 1'b0;
    w0 = wcnt;
    r0 = rcnt;
    do_write(16'hA55A);
    chk(wr_valid && wr_addr == 19'h01234, "R4 stalled write", 32'(wr_addr), 32'h1234);
    repeat (20) @(negedge clk);
    chk(wr_valid && wr_data == 16'hA55A && wr_addr == 19'h01234, "R4 write held",
        32'(wr_data), 32'hA55A);
    put(8'hC0);
    chk(!rd_valid && rcnt == r0, "R11 read waits", 32'(rd_valid), 0);
    @(negedge clk) wr_ready = 1'b1;
    repeat (16) @(negedge clk);
    chk(wcnt == w0 + 1, "R4 write accepted", 32'(wcnt), 32'(w0 + 1));
    chk(rcnt == r0 + 1 && last_raddr == 19'h01235, "R11 deferred read", 32'(last_raddr), 32'h1235);
    w[3:0] = host_out;
    put(8'h40); w[7:4]   = host_out;
    put(8'hC0); w[11:8]  = host_out;
    put(8'h00); w[15:12] = host_out;
    chk(w == mem_f(19'h01235), "R6 deferred read word", 32'(w), 32'(mem_f(19'h01235)));

    // R5 read back-pressure
    @(negedge clk) rd_ready = 1'b0;
    r0 = rcnt;
    put(8'hC0);
    chk(rd_valid && rd_addr == 19'h01236, "R5 stalled read", 32'(rd_addr), 32'h1236);
    repeat (10) @(negedge clk);
    chk(rd_valid && rd_addr == 19'h01236 && rcnt == r0, "R5 read held", 32'(rd_addr), 32'h1236);
    @(negedge clk) rd_ready = 1'b1;
    repeat (16) @(negedge clk);
    w[3:0] = host_out;
    put(8'h40); w[7:4]   = host_out;
    put(8'hC0); w[11:8]  = host_out;
    put(8'h00); w[15:12] = host_out;
    chk(w == mem_f(19'h01236), "R5 read word", 32'(w), 32'(mem_f(19'h01236)));
    do_write(16'h4444);
    chk(last_waddr == 19'h01237, "R5 step on accept", 32'(last_waddr), 32'h1237);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule